// File: doc/BRIEF.md
# Four-Channel Cascadable Down-Counter/Timer

This peripheral holds four independent 8-bit down-counter channels behind a small CPU bus. The bus has a chip select, a two-bit channel select, read and write strobes and an 8-bit data path. Each channel sits at its own consecutive port offset. Software programs a channel with one control byte. A time-constant byte follows that control byte only when the control byte asks for it.

In timer mode a channel counts the system clock through a divide-by-16 or divide-by-256 prescaler. In counter mode it counts edges on its trigger input. Whenever a channel passes through zero it reloads its constant and pulses its zero-count output for one clock. Because of this, wiring one channel's zero-count output to the next channel's trigger input builds a prescaler-plus-timer pair for a periodic tick. A channel can also latch an interrupt request when it reaches zero. For an acknowledged channel, a vector output supplies the stored vector with the channel number folded into it.

Top module: `quad_down_timer`

## Requirements
- R1: A byte with bit 0 = 0, written to a channel that is not waiting for a constant, is an interrupt vector. It is stored only when written to channel 0 and ignored on channels 1 to 3. `vec_out` equals the stored vector with bits 2:1 replaced by `ack_ch` and bit 0 forced to 0.
- R2: A control byte (bit 0 = 1) with bit 1 = 1 stops the channel. Its count holds and no zero-count pulse occurs until a new time constant is loaded.
- R3: Control bit 2 = 1 makes the next byte written to that channel the time constant. When the channel is stopped, that byte is loaded into the counter at once and reads back unchanged.
- R4: In timer mode (control bit 6 = 0), the count decrements once every 16 clocks when bit 5 = 0, or every 256 clocks when bit 5 = 1. The first decrement lands exactly one prescale period after the start.
- R5: In counter mode (control bit 6 = 1), the count decrements on each trigger-input edge of the selected polarity: rising when bit 4 = 1, falling when bit 4 = 0. Edges of the other polarity are ignored.
- R6: In timer mode with control bit 3 = 1, loading the constant does not start counting. Counting starts on the next active trigger edge. With bit 3 = 0, counting starts on the load.
- R7: A time constant of 0 behaves as 256. On passing through zero, the channel reloads its constant automatically.
- R8: On reaching zero, a channel drives its `zc_out` bit high for exactly one clock. That pulse is a valid trigger for a cascaded channel.
- R9: With control bit 7 = 1, reaching zero sets the channel's `irq_req` bit. The bit stays set until `irq_ack` is pulsed with `ack_ch` naming that channel. A new zero in the same cycle wins over the clear.
- R10: With `cs` and `rd` high, `rdata` returns the current count of the channel named by `ch_sel`. Otherwise `rdata` is 0. After reset every count is 0 and no pulse or request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| rd | input | 1 | Read strobe, combinational read |
| ch_sel | input | 2 | Channel (port offset) select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: selected channel's count |
| trig_in | input | 4 | Per-channel trigger/clock inputs |
| zc_out | output | 4 | Per-channel one-clock zero-count pulses |
| irq_req | output | 4 | Per-channel latched interrupt requests |
| irq_ack | input | 1 | Acknowledge pulse, clears request of `ack_ch` |
| ack_ch | input | 2 | Channel being acknowledged / vector channel |
| vec_out | output | 8 | Interrupt vector for `ack_ch` |

## Verification
The counting path is exercised with three stimulus patterns:
- a timer channel on the divide-by-16 prescaler with a small constant;
- a trigger-started timer on the divide-by-256 prescaler;
- a counter channel fed by toggling an external input of the opposite polarity with a constant of 0.

Between them these separate the prescaler choice, the start condition, edge polarity and the 256 wrap. A cascade of channel 0 into a rising-edge counter on channel 1 shows that a one-clock zero-count pulse is a usable trigger. A software reset mid-run shows that the count freezes. Vector writes to channel 0 and to channel 1, read back at several acknowledge channels, separate a stored vector from an ignored one and show where the channel bits go.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

  // Control byte bit positions (software-visible encoding)
  localparam int CB_CTRL = 0;
  localparam int CB_RST  = 1;
  localparam int CB_TC   = 2;
  localparam int CB_TRIG = 3;
  localparam int CB_EDGE = 4;
  localparam int CB_PSC  = 5;
  localparam int CB_MODE = 6;
  localparam int CB_IEN  = 7;

  typedef struct packed {
    logic irq_en;
    logic ctr_mode;
    logic psc_hi;
    logic rise;
    logic trig_start;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_cfg(input logic [7:0] b);
    chan_cfg_t c;
    c.irq_en     = b[CB_IEN];
    c.ctr_mode   = b[CB_MODE];
    c.psc_hi     = b[CB_PSC];
    c.rise       = b[CB_EDGE];
    c.trig_start = b[CB_TRIG];
    return c;
  endfunction

  // Prescale period in clocks for the selected range
  function automatic int unsigned psc_len(input logic hi, input int unsigned lo_len,
                                          input int unsigned hi_len);
    return hi ? hi_len : lo_len;
  endfunction

  // Vector: keep upper bits of the stored byte, insert channel above bit 0
  function automatic logic [7:0] irq_vector(input logic [7:0] base, input logic [7:0] chan,
                                            input int unsigned chw);
    logic [7:0] keep;
    keep = 8'hFF << (chw + 1);
    return (base & keep) | (chan << 1);
  endfunction

endpackage

// File: rtl/qtc_edge.sv
module qtc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic rise,
  output logic hit
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign hit = rise ? (sig & ~sig_q) : (~sig & sig_q);
endmodule

// File: rtl/qtc_prescale.sv
module qtc_prescale import qtc_pkg::*; #(
  parameter int LO = 16,
  parameter int HI = 256,
  localparam int PW = $clog2(HI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic hi,
  output logic tick
);
  logic [PW-1:0] pre;
  logic [PW-1:0] last;

  assign last = PW'(psc_len(hi, LO, HI) - 1);
  assign tick = run & (pre == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (clear)  pre <= '0;
    else if (run)    pre <= tick ? '0 : pre + PW'(1);
  end
endmodule

// File: rtl/qtc_channel.sv
module qtc_channel import qtc_pkg::*; #(
  parameter int DW     = 8,
  parameter int PSC_LO = 16,
  parameter int PSC_HI = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          trig,
  input  logic          ack,
  output logic          zc,
  output logic          irq,
  output logic          vec_take,
  output logic [DW-1:0] count
);
  chan_cfg_t     cfg;
  logic          expect_tc, running, armed;
  logic [DW-1:0] tconst, cnt;
  logic          hit, psc_tick, tick, at_one;
  logic          is_ctrl, is_tc, start_now, trig_go;

  qtc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sig(trig), .rise(cfg.rise), .hit(hit)
  );

  qtc_prescale #(.LO(PSC_LO), .HI(PSC_HI)) u_psc (
    .clk(clk), .rst_n(rst_n),
    .clear(start_now | trig_go),
    .run(running & ~cfg.ctr_mode),
    .hi(cfg.psc_hi),
    .tick(psc_tick)
  );

  assign is_ctrl   = wr_en & ~expect_tc &  wdata[CB_CTRL];
  assign vec_take  = wr_en & ~expect_tc & ~wdata[CB_CTRL];
  assign is_tc     = wr_en & expect_tc;
  assign start_now = is_tc & ~running;
  assign trig_go   = armed & hit;
  assign tick      = running & (cfg.ctr_mode ? hit : psc_tick);
  assign at_one    = (cnt == DW'(1));
  assign count     = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      expect_tc <= 1'b0;
      running   <= 1'b0;
      armed     <= 1'b0;
      tconst    <= '0;
      cnt       <= '0;
      zc        <= 1'b0;
      irq       <= 1'b0;
    end else begin
      zc <= 1'b0;
      if (tick) begin
        if (at_one) begin
          cnt <= tconst;
          zc  <= 1'b1;
        end else begin
          cnt <= cnt - DW'(1);
        end
      end
      if (trig_go) begin
        armed   <= 1'b0;
        running <= 1'b1;
      end
      if (tick & at_one & cfg.irq_en) irq <= 1'b1;
      else if (ack)                   irq <= 1'b0;

      if (is_ctrl) begin
        cfg       <= decode_cfg(wdata[7:0]);
        expect_tc <= wdata[CB_TC];
        if (wdata[CB_RST]) begin
          running <= 1'b0;
          armed   <= 1'b0;
        end
      end
      if (is_tc) begin
        tconst    <= wdata;
        expect_tc <= 1'b0;
        if (!running) begin
          cnt <= wdata;
          if (cfg.trig_start & ~cfg.ctr_mode) armed   <= 1'b1;
          else                                running <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer import qtc_pkg::*; #(
  parameter  int N_CH   = 4,
  parameter  int DW     = 8,
  parameter  int PSC_LO = 16,
  parameter  int PSC_HI = 256,
  localparam int CHW    = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            wr,
  input  logic            rd,
  input  logic [CHW-1:0]  ch_sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [N_CH-1:0] trig_in,
  output logic [N_CH-1:0] zc_out,
  output logic [N_CH-1:0] irq_req,
  input  logic            irq_ack,
  input  logic [CHW-1:0]  ack_ch,
  output logic [7:0]      vec_out
);
  localparam logic [N_CH-1:0] OWNER_MASK = N_CH'(1);

  logic [DW-1:0]   counts [N_CH];
  logic [N_CH-1:0] vec_take;
  logic [7:0]      vec_reg;
  logic            vec_we;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    qtc_channel #(.DW(DW), .PSC_LO(PSC_LO), .PSC_HI(PSC_HI)) u_ch (
      .clk(clk),
      .rst_n(rst_n),
      .wr_en(cs & wr & (ch_sel == CHW'(g))),
      .wdata(wdata),
      .trig(trig_in[g]),
      .ack(irq_ack & (ack_ch == CHW'(g))),
      .zc(zc_out[g]),
      .irq(irq_req[g]),
      .vec_take(vec_take[g]),
      .count(counts[g])
    );
  end

  // Only the first channel owns the vector register
  assign vec_we = |(vec_take & OWNER_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_reg <= '0;
    else if (vec_we) vec_reg <= wdata[7:0];
  end

  assign vec_out = irq_vector(vec_reg, 8'(ack_ch), CHW);
  assign rdata   = (cs & rd) ? counts[ch_sel] : '0;
endmodule

// File: rtl/qtc_checker.sv
module qtc_checker #(
  parameter int N_CH = 4,
  parameter int CHW  = 2,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            rd,
  input logic [DW-1:0]   rdata,
  input logic [N_CH-1:0] zc_out,
  input logic [N_CH-1:0] irq_req,
  input logic            irq_ack,
  input logic [CHW-1:0]  ack_ch
);
  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_zc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      zc_out[i] |=> !zc_out[i]);

    assert_irq_from_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[i]) |-> zc_out[i]);

    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && !(irq_ack && ack_ch == CHW'(i))) |=> irq_req[i]);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && ack_ch == CHW'(i)) |=> (!irq_req[i] || zc_out[i]));
  end

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> (rdata == '0));
endmodule

bind quad_down_timer qtc_checker #(.N_CH(N_CH), .CHW(CHW), .DW(DW)) u_qtc_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .rdata(rdata),
  .zc_out(zc_out), .irq_req(irq_req), .irq_ack(irq_ack), .ack_ch(ack_ch)
);

// File: tb/quad_down_timer_tb.sv
`timescale 1ns/1ps
module quad_down_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] ch_sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] ext = '0;
  logic       casc = 1'b1;
  logic [3:0] trig;
  logic [3:0] zc_out, irq_req;
  logic       irq_ack = 1'b0;
  logic [1:0] ack_ch = '0;
  logic [7:0] vec_out;

  int checks = 0, errors = 0;
  bit done = 0;
  int zc_seen [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  assign trig = {ext[3], ext[2], casc ? zc_out[0] : ext[1], ext[0]};

  quad_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .ch_sel(ch_sel),
    .wdata(wdata), .rdata(rdata), .trig_in(trig), .zc_out(zc_out),
    .irq_req(irq_req), .irq_ack(irq_ack), .ack_ch(ack_ch), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt [4], m_tc [4], m_pre [4];
  bit m_run [4], m_arm [4], m_exp [4], m_ien [4], m_ctr [4], m_psc [4];
  bit m_rise [4], m_ts [4], m_irq [4], m_zc [4], m_prev [4];
  int m_vec;

  always @(posedge clk) begin
    bit tin [4];
    bit e, tk, sf;
    int lim;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_tc[c] = 0; m_pre[c] = 0; m_run[c] = 0; m_arm[c] = 0;
        m_exp[c] = 0; m_ien[c] = 0; m_ctr[c] = 0; m_psc[c] = 0; m_rise[c] = 0;
        m_ts[c] = 0; m_irq[c] = 0; m_zc[c] = 0; m_prev[c] = 0;
      end
      m_vec = 0;
    end else begin
      tin[0] = ext[0]; tin[1] = casc ? m_zc[0] : ext[1];
      tin[2] = ext[2]; tin[3] = ext[3];
      for (int c = 0; c < 4; c++) begin
        e = m_rise[c] ? (tin[c] && !m_prev[c]) : (!tin[c] && m_prev[c]);
        m_prev[c] = tin[c];
        m_zc[c] = 0; sf = 0;
        lim = m_psc[c] ? 256 : 16;
        if (m_run[c]) begin
          if (m_ctr[c]) tk = e;
          else begin
            tk = (m_pre[c] == lim - 1);
            m_pre[c] = tk ? 0 : m_pre[c] + 1;
          end
          if (tk) begin
            if (m_cnt[c] == 1) begin
              m_cnt[c] = m_tc[c]; m_zc[c] = 1; sf = m_ien[c];
            end else m_cnt[c] = (m_cnt[c] + 255) % 256;
          end
        end else if (m_arm[c] && e) begin
          m_arm[c] = 0; m_run[c] = 1; m_pre[c] = 0;
        end
        if (sf) m_irq[c] = 1;
        else if (irq_ack && ack_ch == c) m_irq[c] = 0;
        if (cs && wr && ch_sel == c) begin
          if (m_exp[c]) begin
            m_tc[c] = wdata; m_exp[c] = 0;
            if (!m_run[c]) begin
              m_cnt[c] = wdata; m_pre[c] = 0;
              if (m_ts[c] && !m_ctr[c]) m_arm[c] = 1; else m_run[c] = 1;
            end
          end else if (wdata[0]) begin
            m_ien[c] = wdata[7]; m_ctr[c] = wdata[6]; m_psc[c] = wdata[5];
            m_rise[c] = wdata[4]; m_ts[c] = wdata[3]; m_exp[c] = wdata[2];
            if (wdata[1]) begin m_run[c] = 0; m_arm[c] = 0; end
          end else if (c == 0) m_vec = wdata;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        if (zc_out[c]) zc_seen[c]++;
        chk($sformatf("R8 zero-count pulse ch%0d", c), zc_out[c], m_zc[c]);
        chk($sformatf("R9 interrupt request ch%0d", c), irq_req[c], m_irq[c]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_byte(input int ch, input int val);
    @(negedge clk);
    cs = 1; wr = 1; ch_sel = 2'(ch); wdata = 8'(val);
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  // called at a negedge: combinational read, compared with model and expectation
  task automatic rd_chk(input int ch, input string tag, input int exp);
    cs = 1; rd = 1; ch_sel = 2'(ch);
    #1;
    chk({tag, " (model)"}, rdata, m_cnt[ch]);
    chk(tag, rdata, exp);
    cs = 0; rd = 0;
  endtask

  task automatic vec_chk(input int ch, input int exp);
    ack_ch = 2'(ch);
    #1;
    chk($sformatf("R1 vector for ch%0d", ch), vec_out, exp);
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    irq_ack = 1; ack_ch = 2'(ch);
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v1, v2, z0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    for (int c = 0; c < 4; c++) rd_chk(c, "R10 count after reset", 0);
    chk("R10 no pulses after reset", zc_out, 0);
    chk("R10 no requests after reset", irq_req, 0);

    // R1: vector stored on channel 0 only
    wr_byte(0, 8'hA4);
    vec_chk(0, 8'hA0);
    vec_chk(2, 8'hA4);
    vec_chk(3, 8'hA6);
    wr_byte(1, 8'h38);
    vec_chk(0, 8'hA0);

    // channel 1: counter, rising edge, irq, constant 2, clocked by channel 0
    wr_byte(1, 8'hD5);
    wr_byte(1, 2);
    // channel 0: timer /16, irq, constant 3
    wr_byte(0, 8'h85);
    wr_byte(0, 3);
    rd_chk(0, "R3 constant loaded", 3);
    repeat (15) @(negedge clk);
    rd_chk(0, "R4 no decrement before 16 clocks", 3);
    @(negedge clk);
    rd_chk(0, "R4 decrement at 16 clocks", 2);
    repeat (32) @(negedge clk);
    chk("R9 request after zero", irq_req[0], 1);
    rd_chk(0, "R7 reload after zero", 3);
    ack(0);
    chk("R9 request cleared by acknowledge", irq_req[0], 0);
    @(negedge clk);
    rd_chk(1, "R5 R8 cascade edge counted", 1);
    repeat (200) @(negedge clk);

    // R2: software reset freezes channel 0
    wr_byte(0, 8'h03);
    @(negedge clk);
    cs = 1; rd = 1; ch_sel = 0; #1; v1 = rdata; cs = 0; rd = 0;
    z0 = zc_seen[0];
    repeat (100) @(negedge clk);
    cs = 1; rd = 1; ch_sel = 0; #1; v2 = rdata; cs = 0; rd = 0;
    chk("R2 count holds after reset", v2, v1);
    chk("R2 no pulse after reset", zc_seen[0], z0);

    // R6: channel 2 timer /256, trigger start, rising edge, constant 2
    wr_byte(2, 8'hBD);
    wr_byte(2, 2);
    repeat (40) @(negedge clk);
    rd_chk(2, "R6 waits for trigger", 2);
    ext[2] = 1;
    repeat (256) @(negedge clk);
    rd_chk(2, "R4 /256 not yet decremented", 2);
    @(negedge clk);
    rd_chk(2, "R6 R4 decrement after trigger", 1);

    // R5/R7: channel 3 counter, falling edge, constant 0
    wr_byte(3, 8'h45);
    wr_byte(3, 0);
    z0 = zc_seen[3];
    rd_chk(3, "R7 constant zero loaded", 0);
    ext[3] = 1;
    @(negedge clk);
    @(negedge clk);
    rd_chk(3, "R5 opposite edge ignored", 0);
    ext[3] = 0;
    @(negedge clk);
    @(negedge clk);
    rd_chk(3, "R7 zero wraps to 255", 255);
    for (int k = 0; k < 255; k++) begin
      ext[3] = 1; @(negedge clk);
      ext[3] = 0; @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R8 one pulse after 256 edges", zc_seen[3] - z0, 1);
    rd_chk(3, "R7 reload of zero constant", 0);

    // R2/R3: restart channel 0 after reset with constant 1
    wr_byte(0, 8'h05);
    wr_byte(0, 1);
    rd_chk(0, "R3 reload after reset", 1);
    repeat (60) @(negedge clk);
    finish_run();
  end
endmodule